// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block turns a free-running fast clock and an asynchronous convert command into the timing a subranging converter needs: a sample-and-hold gate, a strobe for the coarse encoder, a strobe for the fine encoder and a one-cycle result-ready pulse. It reacts only to the rising edge of the command, so a command that is high for one tick or for most of its period starts exactly one conversion.

Each accepted command opens a hold phase of a fixed number of conversion ticks. A one-hot token then walks through a three-stage register, and each stage gives one of the strobes. The block also counts the ticks between accepted commands. Once two commands have been seen, the track phase that follows each conversion lasts for the last measured period minus the conversion ticks. After that the gate returns to hold and waits for the next command. A command that arrives while a conversion is still running is dropped, and a sticky flag records the event.

Top module: `conv_timing_seq`

## Requirements
- R1: While `rst` is high, and after it is released, `sh_track` is 1, the three strobes are 0 and `overrun` is 0.
- R2: Let edge k be the first clock edge that samples `convert_cmd` high after it was sampled low. For an accepted command, `msb_strobe` is 1 for exactly one cycle, and it goes high at edge k+2.
- R3: `lsb_strobe` is 1 for exactly the cycle after the `msb_strobe` cycle. `data_valid` is 1 for exactly the cycle after that. At most one of the three is ever high at a time.
- R4: The command's high time, from one tick up to one tick less than its period, has no effect: each rising edge gives exactly one strobe sequence.
- R5: `sh_track` is 0 (hold) for exactly CONV_TICKS cycles, starting in the `msb_strobe` cycle of each accepted command.
- R6: After the first accepted command since reset, `sh_track` returns to 1 when the hold ends and stays 1 until the next accepted command.
- R7: Let P be the number of ticks between the latest two accepted commands. After the hold of the later command, `sh_track` is 1 for P − CONV_TICKS cycles and then 0 until the next accepted command.
- R8: A command is dropped when its detection edge (k+2) falls 1 to 3 cycles after the detection edge of the last accepted command. A dropped command produces no strobes and sets `overrun` at that edge.
- R9: Once `overrun` is set, it stays 1 until reset, and reset clears it.
- R10: The period is measured between accepted commands only. A dropped command does not restart the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst | input | 1 | Synchronous active-high reset |
| convert_cmd | input | 1 | Asynchronous convert command; its rising edge starts a conversion |
| sh_track | output | 1 | Sample-and-hold gate: 1 = track, 0 = hold |
| msb_strobe | output | 1 | Strobe for the coarse encoder latch |
| lsb_strobe | output | 1 | Strobe for the fine encoder latch |
| data_valid | output | 1 | One-cycle pulse that marks the corrected word as ready |
| overrun | output | 1 | Sticky flag: a command arrived during a running conversion |

## Verification
The bench sweeps the command period from the shortest accepted spacing upward. It does so with a one-tick pulse, a half-period pulse and a pulse one tick short of the period. A design that acted on level instead of edge would fire repeated sequences for the wide pulses, and an off-by-one in the synchronizer would shift every strobe by a cycle. An irregular train checks that each track window follows the immediately preceding period rather than a stale one, and that the first window after reset stays open. Commands placed two and three ticks after an accepted one must be dropped, while the fourth tick is accepted. A busy test that counted one stage short or long would either lose a good command or restart mid-conversion. That run also shows whether a dropped command wrongly restarts the period count, which would shrink the next window.

// File: rtl/ctseq_pkg.sv
package ctseq_pkg;
  // Gate phase: free track before any period is known, hold during
  // conversion, timed track window, parked hold awaiting a command.
  typedef enum logic [1:0] {
    PH_OPEN   = 2'd0,
    PH_HOLD   = 2'd1,
    PH_WINDOW = 2'd2,
    PH_PARK   = 2'd3
  } phase_t;
endpackage

// File: rtl/ctseq_edge_sync.sv
module ctseq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_async,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cmd_async};
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~hist_q;
endmodule

// File: rtl/ctseq_strobe_chain.sv
module ctseq_strobe_chain #(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  output logic [STAGES-1:0] taps,
  output logic              busy
);
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) taps[0] <= 1'b0;
          else     taps[0] <= load;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) taps[g] <= 1'b0;
          else     taps[g] <= taps[g-1];
        end
      end
    end
  endgenerate

  assign busy = |taps;
endmodule

// File: rtl/ctseq_gate_timer.sv
module ctseq_gate_timer
  import ctseq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int CONV_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic track,
  output logic holding
);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}} - 1'b1;
  localparam logic [CNT_W-1:0] CONV_W   = CNT_W'(CONV_TICKS);
  localparam logic [CNT_W-1:0] CONV_M1  = CNT_W'(CONV_TICKS - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] per_cnt_q;
  logic [CNT_W-1:0] win_q;
  logic             seen_q;
  logic             have_win_q;
  logic [CNT_W-1:0] per_now;

  assign per_now = per_cnt_q + 1'b1;

  // Period measurement between accepted starts, saturating.
  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt_q  <= '0;
      win_q      <= '0;
      seen_q     <= 1'b0;
      have_win_q <= 1'b0;
    end else if (start) begin
      per_cnt_q <= '0;
      seen_q    <= 1'b1;
      if (seen_q) begin
        have_win_q <= 1'b1;
        // Clamp so the window never collapses to zero ticks.
        win_q <= (per_now > CONV_W) ? (per_now - CONV_W) : {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end else if (per_cnt_q != CNT_SAT) begin
      per_cnt_q <= per_cnt_q + 1'b1;
    end
  end

  // Phase sequencing of the gate.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OPEN;
      tmr_q   <= '0;
    end else if (start) begin
      phase_q <= PH_HOLD;
      tmr_q   <= CONV_M1;
    end else begin
      case (phase_q)
        PH_HOLD: begin
          if (tmr_q == '0) begin
            if (have_win_q) begin
              phase_q <= PH_WINDOW;
              tmr_q   <= win_q - 1'b1;
            end else begin
              phase_q <= PH_OPEN;
            end
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        PH_WINDOW: begin
          if (tmr_q == '0) phase_q <= PH_PARK;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign track   = (phase_q == PH_OPEN) || (phase_q == PH_WINDOW);
  assign holding = (phase_q == PH_HOLD);
endmodule

// File: rtl/conv_timing_seq.sv
module conv_timing_seq #(
  parameter int CNT_W       = 12,
  parameter int CONV_TICKS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic convert_cmd,
  output logic sh_track,
  output logic msb_strobe,
  output logic lsb_strobe,
  output logic data_valid,
  output logic overrun
);
  localparam int STAGES = 3;

  logic              edge_rise;
  logic              accept;
  logic              seq_busy;
  logic              chain_busy;
  logic              hold_busy;
  logic [STAGES-1:0] taps;

  ctseq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cmd_async (convert_cmd),
    .rise      (edge_rise)
  );

  assign seq_busy = chain_busy | hold_busy;
  assign accept   = edge_rise & ~seq_busy;

  ctseq_strobe_chain #(.STAGES(STAGES)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .taps (taps),
    .busy (chain_busy)
  );

  ctseq_gate_timer #(.CNT_W(CNT_W), .CONV_TICKS(CONV_TICKS)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .track   (sh_track),
    .holding (hold_busy)
  );

  always_ff @(posedge clk) begin
    if (rst)                        overrun <= 1'b0;
    else if (edge_rise && seq_busy) overrun <= 1'b1;
  end

  assign msb_strobe = taps[0];
  assign lsb_strobe = taps[1];
  assign data_valid = taps[STAGES-1];
endmodule

// File: rtl/ctseq_chk.sv
module ctseq_chk (
  input logic clk,
  input logic rst,
  input logic sh_track,
  input logic msb_strobe,
  input logic lsb_strobe,
  input logic data_valid,
  input logic overrun,
  input logic edge_rise,
  input logic seq_busy
);
  // R3
  lsb_after_msb_chk: assert property (@(posedge clk) disable iff (rst)
    msb_strobe |=> lsb_strobe);

  // R3
  valid_after_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    lsb_strobe |=> data_valid);

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({msb_strobe, lsb_strobe, data_valid}));

  // R5
  hold_during_msb_chk: assert property (@(posedge clk) disable iff (rst)
    msb_strobe |-> !sh_track);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_rise && seq_busy) |=> (!msb_strobe && overrun));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind conv_timing_seq ctseq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sh_track   (sh_track),
  .msb_strobe (msb_strobe),
  .lsb_strobe (lsb_strobe),
  .data_valid (data_valid),
  .overrun    (overrun),
  .edge_rise  (edge_rise),
  .seq_busy   (seq_busy)
);

// File: tb/tb_conv_timing_seq.sv
module tb_conv_timing_seq;
  localparam int CONV = 3;
  localparam int WMAX = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd = 1'b0;
  logic sh_track, msb_strobe, lsb_strobe, data_valid, overrun;

  int vectors = 0;
  int errors  = 0;

  logic wave [0:WMAX-1];
  int   acc  [0:31];
  int   nacc;
  int   ign_first;

  always #5 clk = ~clk;

  conv_timing_seq dut (
    .clk         (clk),
    .rst         (rst),
    .convert_cmd (cmd),
    .sh_track    (sh_track),
    .msb_strobe  (msb_strobe),
    .lsb_strobe  (lsb_strobe),
    .data_valid  (data_valid),
    .overrun     (overrun)
  );

  task automatic chk(input logic got, input logic exp, input string tag, input int t);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, t, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic clear_plan();
    for (int i = 0; i < WMAX; i++) wave[i] = 1'b0;
    nacc = 0;
    ign_first = -1;
  endtask

  // Rise first sampled at edge k, high for w ticks. Detection edge is k+2;
  // dropped if 1..3 cycles after the last accepted detection edge (R8).
  task automatic add_cmd(input int k, input int w);
    int a;
    for (int i = k; i < k + w; i++) wave[i] = 1'b1;
    a = k + 2;
    if (nacc == 0 || a - acc[nacc-1] >= 4) begin
      acc[nacc] = a;
      nacc++;
    end else if (ign_first < 0) begin
      ign_first = a;
    end
  endtask

  function automatic logic is_acc(input int t);
    for (int i = 0; i < nacc; i++) if (acc[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_track(input int t);
    int j = -1;
    int win;
    for (int i = 0; i < nacc; i++) if (acc[i] <= t) j = i;
    if (j < 0) return 1'b1;
    if (t < acc[j] + CONV) return 1'b0;
    if (j == 0) return 1'b1;
    win = (acc[j] - acc[j-1]) - CONV;
    if (win < 1) win = 1;
    return (t < acc[j] + CONV + win) ? 1'b1 : 1'b0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    cmd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sh_track,   1'b1, "R1 track in reset", -1);
    chk(msb_strobe, 1'b0, "R1 msb in reset", -1);
    chk(lsb_strobe, 1'b0, "R1 lsb in reset", -1);
    chk(data_valid, 1'b0, "R1 valid in reset", -1);
    chk(overrun,    1'b0, "R1 R9 overrun cleared by reset", -1);
    rst = 1'b0;
  endtask

  task automatic run(input int tcount);
    for (int t = 0; t < tcount; t++) begin
      cmd = wave[t];
      @(posedge clk);
      @(negedge clk);
      chk(msb_strobe, is_acc(t),     "R2 R4 msb_strobe", t);
      chk(lsb_strobe, is_acc(t - 1), "R3 lsb_strobe", t);
      chk(data_valid, is_acc(t - 2), "R3 data_valid", t);
      chk(sh_track,   exp_track(t),  "R5 R6 R7 sh_track", t);
      chk(overrun, (ign_first >= 0 && t >= ign_first) ? 1'b1 : 1'b0, "R8 R9 overrun", t);
    end
    cmd = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int p = 4; p <= 12; p++) begin
      for (int ws = 0; ws < 3; ws++) begin
        int w = (ws == 0) ? 1 : (ws == 1) ? p / 2 : p - 1;
        do_reset();
        clear_plan();
        for (int i = 0; i < 4; i++) add_cmd(3 + i * p, w);
        run(3 + 5 * p + 10);
      end
    end

    // R7 irregular spacing: each window follows the latest period
    do_reset();
    clear_plan();
    add_cmd(3, 1);
    add_cmd(8, 2);
    add_cmd(17, 1);
    add_cmd(21, 2);
    add_cmd(35, 1);
    add_cmd(41, 3);
    run(70);

    // R8 R10 drops at +2 and +3, accepts at +5, period spans dropped edges
    do_reset();
    clear_plan();
    add_cmd(3, 1);
    add_cmd(5, 1);
    add_cmd(8, 1);
    add_cmd(11, 1);
    add_cmd(20, 1);
    run(50);

    // R9 reset clears the sticky flag
    do_reset();
    clear_plan();
    run(6);

    summary();
  end
endmodule